// File: doc/BRIEF.md
# Descriptor-Chained Display Frame Fetcher

This block pulls display data out of memory by walking a linked list of four-word descriptors. Each descriptor gives the address of the next descriptor, the start address of a payload, a frame tag, and a command word. The command word carries the payload length in 32-bit words and a flag that decides where the payload goes. Palette payloads are written into a palette store through an indexed write port. Frame payloads are streamed in order to a pixel output that can stall. Chains never terminate, so a descriptor that names itself repeats one frame, and a palette descriptor and a frame descriptor that name each other reload the palette ahead of every frame.

The payload is read in bursts of up to 16 words over a request/acknowledge read port, with the final burst shortened to what is left. Each channel has its own start-descriptor input and its own memory port. The lower-panel channel, channel 1 and above, only runs while dual-panel operation is selected. Each channel is driven by one state machine with these states: IDLE, DESC_REQ, DESC_DAT, BURST_REQ, BURST_DAT and NEXT. It moves IDLE→DESC_REQ when run is high, DESC_REQ→DESC_DAT on acknowledge, DESC_DAT→DESC_REQ on each of the first three descriptor words, and DESC_DAT→BURST_REQ on the fourth word, or DESC_DAT→NEXT when the length is zero. It moves BURST_REQ→BURST_DAT on acknowledge, BURST_DAT→BURST_REQ after a burst that leaves words outstanding, and BURST_DAT→NEXT after the last payload word. From NEXT it goes to DESC_REQ while run stays high, and otherwise to IDLE.

Top module: `fetch_top`

## Requirements
- R1: While reset is held, every channel keeps rd_req, pix_valid, pal_we and frame_done low.
- R2: A descriptor is read as four single-word requests (length 1) at byte addresses D, D+4, D+8 and D+12, in that order, before any payload request. The words are taken as next-descriptor address, payload address, frame tag and command.
- R3: Command bits [LEN_W-1:0] give the payload length in 32-bit words, and bit 31 set marks a palette payload. Bits 30 down to LEN_W have no effect.
- R4: The payload is requested in bursts at the payload address plus 64·k. Each burst is 16 words, except the last, which carries the remaining 1 to 16 words. A length of zero issues no payload request. Every request length lies in 1..16.
- R5: Palette payload words appear on pal_we/pal_data with pal_idx counting 0, 1, 2 and so on from each palette descriptor's start. No pixel is output for them.
- R6: Frame payload words appear on pix_valid/pix_data in memory order. When pix_ready is low, the read data is held off (rd_ready low) and no word is lost or repeated.
- R7: After a descriptor completes, the next fetch starts at its next-descriptor address, so a self-linked descriptor repeats. frame_done pulses for exactly one cycle after each frame descriptor, with frame_id holding that descriptor's tag. Palette descriptors raise no frame_done.
- R8: Channels above 0 fetch only while dual_en is high, each starting from its own start_desc field.
- R9: With run low, an idle channel issues no request. When run falls, a channel stops at the next descriptor boundary.
- R10: Once rd_req is raised, it stays high with rd_addr and rd_len unchanged until rd_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables fetching on all enabled channels |
| dual_en | input | 1 | Enables the lower-panel channel(s) |
| start_desc | input | NCH*32 | First-descriptor byte address per channel |
| rd_req | output | NCH | Read request per channel |
| rd_addr | output | NCH*32 | Read byte address |
| rd_len | output | NCH*BL_W | Read length in words (1..BURST) |
| rd_ack | input | NCH | Request accepted |
| rd_valid | input | NCH | Read data beat valid |
| rd_data | input | NCH*32 | Read data |
| rd_ready | output | NCH | Fetcher can take a data beat |
| pix_valid | output | NCH | Pixel word valid |
| pix_data | output | NCH*32 | Pixel word |
| pix_ready | input | NCH | Downstream can take a pixel word |
| pal_we | output | NCH | Palette write strobe |
| pal_idx | output | NCH*PAL_AW | Palette entry index |
| pal_data | output | NCH*32 | Palette entry data |
| frame_done | output | NCH | One-cycle pulse at the end of a frame descriptor |
| frame_id | output | NCH*32 | Tag of the current descriptor |

## Verification
The assertions assume that memory returns exactly rd_len beats per accepted request, and never before the acknowledge. They also assume it raises rd_ack only while rd_req is high, and that descriptors carry lengths below 2^LEN_W. The bench memory model acknowledges one cycle after seeing a request, streams exactly the requested count, and only advances a beat when rd_ready is high. Every descriptor the bench writes has a small length and payload addresses that stay inside the modelled memory.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int WORD_W   = 32;
    localparam int PAL_FLAG = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_DAT,
        ST_BURST_REQ,
        ST_BURST_DAT,
        ST_NEXT
    } fetch_state_t;
endpackage

// File: rtl/burst_sizer.sv
module burst_sizer #(
    parameter int LEN_W = 24,
    parameter int BURST = 16,
    parameter int BL_W  = $clog2(BURST + 1)
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [BL_W-1:0]  len
);
    always_comb begin
        if (remaining >= LEN_W'(BURST))
            len = BL_W'(BURST);
        else
            len = remaining[BL_W-1:0];
    end
endmodule

// File: rtl/fetch_engine.sv
module fetch_engine
    import fetch_pkg::*;
#(
    parameter int LEN_W  = 24,
    parameter int BURST  = 16,
    parameter int PAL_AW = 8,
    parameter int BL_W   = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] start_addr,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    output logic [BL_W-1:0]   rd_len,
    input  logic              rd_ack,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_ready,
    output logic              pix_valid,
    output logic [WORD_W-1:0] pix_data,
    input  logic              pix_ready,
    output logic              pal_we,
    output logic [PAL_AW-1:0] pal_idx,
    output logic [WORD_W-1:0] pal_data,
    output logic              frame_done,
    output logic [WORD_W-1:0] frame_id
);
    fetch_state_t state, state_nx;

    logic [WORD_W-1:0] cur_desc, nxt_desc, src, fid;
    logic [LEN_W-1:0]  remaining;
    logic [BL_W-1:0]   beats, burst_len;
    logic [1:0]        word_idx;
    logic              is_pal;
    logic [PAL_AW-1:0] pal_cnt;
    logic              beat;

    burst_sizer #(.LEN_W(LEN_W), .BURST(BURST), .BL_W(BL_W)) u_sizer (
        .remaining (remaining),
        .len       (burst_len)
    );

    assign beat = (state == ST_BURST_DAT) && rd_valid && rd_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (run) state_nx = ST_DESC_REQ;
            ST_DESC_REQ:  if (rd_ack) state_nx = ST_DESC_DAT;
            ST_DESC_DAT:
                if (rd_valid) begin
                    if (word_idx != 2'd3)
                        state_nx = ST_DESC_REQ;
                    else if (rd_data[LEN_W-1:0] == '0)
                        state_nx = ST_NEXT;
                    else
                        state_nx = ST_BURST_REQ;
                end
            ST_BURST_REQ: if (rd_ack) state_nx = ST_BURST_DAT;
            ST_BURST_DAT:
                if (beat && beats == BL_W'(1))
                    state_nx = (remaining == LEN_W'(1)) ? ST_NEXT : ST_BURST_REQ;
            ST_NEXT:      state_nx = run ? ST_DESC_REQ : ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req     = 1'b0;
        rd_addr    = '0;
        rd_len     = '0;
        rd_ready   = 1'b0;
        unique case (state)
            ST_DESC_REQ: begin
                rd_req  = 1'b1;
                rd_addr = cur_desc + WORD_W'({word_idx, 2'b00});
                rd_len  = BL_W'(1);
            end
            ST_DESC_DAT:  rd_ready = 1'b1;
            ST_BURST_REQ: begin
                rd_req  = 1'b1;
                rd_addr = src;
                rd_len  = burst_len;
            end
            ST_BURST_DAT: rd_ready = is_pal | pix_ready;
            default: ;
        endcase
        pix_valid  = beat && !is_pal;
        pal_we     = beat && is_pal;
        frame_done = (state == ST_NEXT) && !is_pal;
    end

    assign pix_data = rd_data;
    assign pal_data = rd_data;
    assign pal_idx  = pal_cnt;
    assign frame_id = fid;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_desc  <= '0;
            nxt_desc  <= '0;
            src       <= '0;
            fid       <= '0;
            remaining <= '0;
            beats     <= '0;
            word_idx  <= '0;
            is_pal    <= 1'b0;
            pal_cnt   <= '0;
        end else begin
            if (state == ST_IDLE && run) begin
                cur_desc <= start_addr;
                word_idx <= '0;
            end
            if (state == ST_DESC_DAT && rd_valid) begin
                word_idx <= word_idx + 2'd1;
                unique case (word_idx)
                    2'd0: nxt_desc <= rd_data;
                    2'd1: src      <= rd_data;
                    2'd2: fid      <= rd_data;
                    2'd3: begin
                        remaining <= rd_data[LEN_W-1:0];
                        is_pal    <= rd_data[PAL_FLAG];
                        pal_cnt   <= '0;
                    end
                    default: ;
                endcase
            end
            if (state == ST_BURST_REQ && rd_ack)
                beats <= burst_len;
            if (beat) begin
                src       <= src + WORD_W'(4);
                remaining <= remaining - LEN_W'(1);
                beats     <= beats - BL_W'(1);
                if (is_pal) pal_cnt <= pal_cnt + PAL_AW'(1);
            end
            if (state == ST_NEXT)
                cur_desc <= nxt_desc;
        end
    end
endmodule

// File: rtl/fetch_top.sv
module fetch_top
    import fetch_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int LEN_W  = 24,
    parameter int BURST  = 16,
    parameter int PAL_AW = 8,
    localparam int BL_W  = $clog2(BURST + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    dual_en,
    input  logic [NCH*WORD_W-1:0]   start_desc,
    output logic [NCH-1:0]          rd_req,
    output logic [NCH*WORD_W-1:0]   rd_addr,
    output logic [NCH*BL_W-1:0]     rd_len,
    input  logic [NCH-1:0]          rd_ack,
    input  logic [NCH-1:0]          rd_valid,
    input  logic [NCH*WORD_W-1:0]   rd_data,
    output logic [NCH-1:0]          rd_ready,
    output logic [NCH-1:0]          pix_valid,
    output logic [NCH*WORD_W-1:0]   pix_data,
    input  logic [NCH-1:0]          pix_ready,
    output logic [NCH-1:0]          pal_we,
    output logic [NCH*PAL_AW-1:0]   pal_idx,
    output logic [NCH*WORD_W-1:0]   pal_data,
    output logic [NCH-1:0]          frame_done,
    output logic [NCH*WORD_W-1:0]   frame_id
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ch_run;
        if (c == 0) begin : g_upper
            assign ch_run = run;
        end else begin : g_lower
            assign ch_run = run && dual_en;
        end

        fetch_engine #(
            .LEN_W(LEN_W), .BURST(BURST), .PAL_AW(PAL_AW), .BL_W(BL_W)
        ) u_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ch_run),
            .start_addr (start_desc[c*WORD_W +: WORD_W]),
            .rd_req     (rd_req[c]),
            .rd_addr    (rd_addr[c*WORD_W +: WORD_W]),
            .rd_len     (rd_len[c*BL_W +: BL_W]),
            .rd_ack     (rd_ack[c]),
            .rd_valid   (rd_valid[c]),
            .rd_data    (rd_data[c*WORD_W +: WORD_W]),
            .rd_ready   (rd_ready[c]),
            .pix_valid  (pix_valid[c]),
            .pix_data   (pix_data[c*WORD_W +: WORD_W]),
            .pix_ready  (pix_ready[c]),
            .pal_we     (pal_we[c]),
            .pal_idx    (pal_idx[c*PAL_AW +: PAL_AW]),
            .pal_data   (pal_data[c*WORD_W +: WORD_W]),
            .frame_done (frame_done[c]),
            .frame_id   (frame_id[c*WORD_W +: WORD_W])
        );
    end
endmodule

// File: rtl/fetch_top_chk.sv
module fetch_top_chk #(
    parameter int NCH    = 2,
    parameter int BURST  = 16,
    parameter int BL_W   = $clog2(BURST + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCH-1:0]      rd_req,
    input logic [NCH*32-1:0]   rd_addr,
    input logic [NCH*BL_W-1:0] rd_len,
    input logic [NCH-1:0]      rd_ack,
    input logic [NCH-1:0]      pix_valid,
    input logic [NCH-1:0]      pal_we,
    input logic [NCH-1:0]      frame_done
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[c] |-> (rd_len[c*BL_W +: BL_W] >= BL_W'(1) &&
                           rd_len[c*BL_W +: BL_W] <= BL_W'(BURST)));

        p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req[c] && !rd_ack[c]) |=> (rd_req[c] &&
                $stable(rd_addr[c*32 +: 32]) && $stable(rd_len[c*BL_W +: BL_W])));

        p_route_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(pix_valid[c] && pal_we[c]));

        p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            frame_done[c] |=> !frame_done[c]);
    end
endmodule

bind fetch_top fetch_top_chk #(.NCH(NCH), .BURST(BURST), .BL_W(BL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_len     (rd_len),
    .rd_ack     (rd_ack),
    .pix_valid  (pix_valid),
    .pal_we     (pal_we),
    .frame_done (frame_done)
);

// File: tb/tb_fetch_top.sv
module tb_fetch_top;
    localparam int NCH = 2;
    localparam int BLW = 5;
    localparam int PAW = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               run = 1'b0;
    logic               dual_en = 1'b0;
    logic [NCH*32-1:0]  start_desc = '0;
    logic [NCH-1:0]     rd_req, rd_ack, rd_valid, rd_ready;
    logic [NCH*32-1:0]  rd_addr, rd_data, pix_data, pal_data, frame_id;
    logic [NCH*BLW-1:0] rd_len;
    logic [NCH-1:0]     pix_valid, pix_ready, pal_we, frame_done;
    logic [NCH*PAW-1:0] pal_idx;

    always #4 clk = ~clk;

    fetch_top #(.NCH(NCH)) dut (.*);

    // memory model
    logic [31:0] mem [0:511];
    logic [7:0]  cyc;
    logic        stall = 1'b0;
    always_ff @(posedge clk) cyc <= cyc + 8'd1;
    assign pix_ready = stall ? {NCH{cyc[1]}} : {NCH{1'b1}};

    for (genvar g = 0; g < NCH; g++) begin : g_mem
        logic        busy, ack_r, val_r;
        logic [31:0] ptr, dat_r;
        logic [4:0]  cnt;
        assign rd_ack[g]            = ack_r;
        assign rd_valid[g]          = val_r;
        assign rd_data[g*32 +: 32]  = dat_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy <= 1'b0; ack_r <= 1'b0; val_r <= 1'b0;
                ptr <= '0; cnt <= '0; dat_r <= '0;
            end else if (!busy) begin
                if (rd_req[g] && ack_r) begin
                    ack_r <= 1'b0;
                    busy  <= 1'b1;
                    ptr   <= rd_addr[g*32 +: 32];
                    cnt   <= rd_len[g*BLW +: BLW];
                    val_r <= 1'b1;
                    dat_r <= mem[rd_addr[g*32+2 +: 9]];
                end else begin
                    ack_r <= rd_req[g];
                end
            end else if (val_r && rd_ready[g]) begin
                if (cnt == 5'd1) begin
                    busy  <= 1'b0;
                    val_r <= 1'b0;
                end else begin
                    cnt   <= cnt - 5'd1;
                    ptr   <= ptr + 32'd4;
                    dat_r <= mem[ptr[10:2] + 9'd1];
                end
            end
        end
    end

    // monitors
    logic [31:0] cap  [NCH][128];
    logic [31:0] palv [NCH][32];
    logic [7:0]  pali [NCH][32];
    logic [31:0] hsa  [NCH][64];
    logic [4:0]  hsl  [NCH][64];
    int          cap_n [NCH];
    int          pal_n [NCH];
    int          hs_n  [NCH];
    int          fd_n  [NCH];
    logic [31:0] last_fid [NCH];
    logic        pend [NCH];
    logic [31:0] pend_a [NCH];
    int          hold_err = 0;

    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (pix_valid[c]) begin
                if (cap_n[c] < 128) cap[c][cap_n[c]] = pix_data[c*32 +: 32];
                cap_n[c]++;
            end
            if (pal_we[c]) begin
                if (pal_n[c] < 32) begin
                    palv[c][pal_n[c]] = pal_data[c*32 +: 32];
                    pali[c][pal_n[c]] = pal_idx[c*PAW +: PAW];
                end
                pal_n[c]++;
            end
            if (rd_req[c] && rd_ack[c]) begin
                if (hs_n[c] < 64) begin
                    hsa[c][hs_n[c]] = rd_addr[c*32 +: 32];
                    hsl[c][hs_n[c]] = rd_len[c*BLW +: BLW];
                end
                hs_n[c]++;
            end
            if (frame_done[c]) begin
                fd_n[c]++;
                last_fid[c] = frame_id[c*32 +: 32];
            end
            if (pend[c] && (!rd_req[c] || rd_addr[c*32 +: 32] != pend_a[c]))
                hold_err++;
            pend[c]   = rd_req[c] && !rd_ack[c];
            pend_a[c] = rd_addr[c*32 +: 32];
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int c = 0; c < NCH; c++) begin
            cap_n[c] = 0; pal_n[c] = 0; hs_n[c] = 0; fd_n[c] = 0;
            pend[c] = 1'b0;
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] nx, src, fid, cmd);
        mem[a/4]     = nx;
        mem[a/4 + 1] = src;
        mem[a/4 + 2] = fid;
        mem[a/4 + 3] = cmd;
    endtask

    task automatic run_frames(input int ch, input int n);
        int k = 0;
        run = 1'b1;
        while (k < n) begin
            @(negedge clk);
            if (frame_done[ch]) k++;
        end
        run = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    // {len[31:24], bursts[23:16], last[15:8], junk[1], stall[0]}
    localparam logic [31:0] VEC [5] = '{
        32'h10_01_10_00, 32'h01_01_01_00, 32'h25_03_05_03,
        32'h20_02_10_01, 32'h00_00_00_00
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 32'hC0DE_0000 | i;
        clear_logs();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_req == 0 && pix_valid == 0 && pal_we == 0 && frame_done == 0,
              "R1 outputs in reset", {rd_req, pix_valid, pal_we, frame_done}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(hs_n[0] == 0 && hs_n[1] == 0, "R9 no request while run low", hs_n[0] + hs_n[1], 0);

        // table of frame vectors on channel 0, self-linked descriptor at 0x000
        for (int v = 0; v < 5; v++) begin
            int L, nb, lb, bad;
            L  = int'(VEC[v][31:24]);
            nb = int'(VEC[v][23:16]);
            lb = int'(VEC[v][15:8]);
            stall = VEC[v][0];
            put_desc(0, 32'h0, 32'h400, 32'h100 + v, L | (VEC[v][1] ? 32'h3C00_0000 : 32'h0));
            start_desc[31:0] = 32'h0;
            clear_logs();
            run_frames(0, 1);
            check(cap_n[0] == L, "R3 R6 pixel word count", cap_n[0], L);
            bad = 0;
            for (int i = 0; i < L; i++) if (cap[0][i] != mem[256 + i]) bad++;
            check(bad == 0, "R6 pixel data order", bad, 0);
            bad = 0;
            for (int i = 0; i < 4; i++) if (hsa[0][i] != 4 * i || hsl[0][i] != 5'd1) bad++;
            check(bad == 0, "R2 descriptor reads", bad, 0);
            check(hs_n[0] - 4 == nb, "R4 burst count", hs_n[0] - 4, nb);
            if (nb > 0) begin
                check(hsl[0][hs_n[0] - 1] == lb, "R4 last burst length", hsl[0][hs_n[0] - 1], lb);
                bad = 0;
                for (int k = 0; k < nb; k++) if (hsa[0][4 + k] != 32'h400 + 64 * k) bad++;
                check(bad == 0, "R4 burst addresses", bad, 0);
            end
            check(fd_n[0] == 1 && last_fid[0] == 32'h100 + v, "R7 frame tag", last_fid[0], 32'h100 + v);
        end
        stall = 1'b0;

        // R7: self-linked descriptor repeats
        put_desc(0, 32'h0, 32'h400, 32'h42, 32'd5);
        clear_logs();
        run_frames(0, 2);
        check(hs_n[0] == 10 && hsa[0][5] == 32'h0, "R7 self loop refetch", hs_n[0], 10);
        check(cap_n[0] == 10 && cap[0][5] == mem[256], "R7 repeated frame data", cap[0][5], mem[256]);

        // R9: after run drops, no further requests
        begin
            int h0;
            h0 = hs_n[0];
            repeat (30) @(negedge clk);
            check(hs_n[0] == h0, "R9 stop at boundary", hs_n[0], h0);
        end

        // R5: palette and frame descriptors linked to each other
        put_desc(16, 32'h20, 32'h600, 32'h77, 32'h8000_0004);
        put_desc(32, 32'h10, 32'h400, 32'h55, 32'd3);
        start_desc[31:0] = 32'h10;
        clear_logs();
        run_frames(0, 2);
        check(pal_n[0] == 8, "R5 palette reloaded per frame", pal_n[0], 8);
        begin
            int bad = 0;
            for (int i = 0; i < 8; i++)
                if (palv[0][i] != mem[384 + i % 4] || pali[0][i] != 8'(i % 4)) bad++;
            check(bad == 0, "R5 palette data and index", bad, 0);
            bad = 0;
            for (int i = 0; i < 6; i++) if (cap[0][i] != mem[256 + i % 3]) bad++;
            check(cap_n[0] == 6 && bad == 0, "R5 no pixels from palette", cap_n[0], 6);
        end
        check(fd_n[0] == 2 && last_fid[0] == 32'h55, "R7 no done for palette", fd_n[0], 2);

        // R8: lower channel
        put_desc(0, 32'h0, 32'h400, 32'h11, 32'd8);
        put_desc(64, 32'h40, 32'h700, 32'h99, 32'd20);
        start_desc = {32'h40, 32'h0};
        dual_en = 1'b0;
        clear_logs();
        run_frames(0, 1);
        check(hs_n[1] == 0 && cap_n[1] == 0, "R8 lower idle without dual", hs_n[1], 0);
        dual_en = 1'b1;
        clear_logs();
        run_frames(1, 1);
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) if (cap[1][i] != mem[448 + i]) bad++;
            check(cap_n[1] == 20 && bad == 0, "R8 lower channel data", cap_n[1], 20);
        end
        check(hsa[1][0] == 32'h40 && last_fid[1] == 32'h99, "R8 lower start address", hsa[1][0], 32'h40);

        check(hold_err == 0, "R10 request held until ack", hold_err, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule